// File: doc/BRIEF.md
# Feed-Protected Clock Multiplier Control Unit

This block holds the settings of an on-chip clock multiplier behind a small register interface. Software writes a new multiplier, divider, enable and connect setting into holding registers. Those values stay staged and have no effect until software writes a two-value unlock pattern to a dedicated feed register. At that point the whole staged set becomes the active set in a single step, so the multiplier loop never sees a half-written configuration.

The active settings drive the loop (`pll_mult`, `pll_div`, `pll_en`). They also drive a clock-select output that picks the multiplied clock only when the loop is both enabled and connected. A read-only status word reports the active values and the live lock flag. The lock flag also feeds an interrupt request that software can mask, so software does not have to poll for lock. A power-down input forces the loop off and back to the oscillator. The analog loop itself is outside this block: lock arrives on an input.

Top module: `pllctl_unit`

## Requirements
- R1: A write to CTRL (address 0; bit 0 enable, bit 1 connect) or to CFG (address 1; bits 4:0 multiplier, bits 6:5 divider) changes only the staged copy. A read of that address returns the staged value in the same layout. The active outputs and the status word do not change.
- R2: When software writes 0xAA to FEED (address 3, value in bits 7:0) and then 0x55, all staged values are copied to the active set at the clock edge of the 0x55 write. They show on the outputs in the cycle after that edge. Cycles with no bus access may lie between the two writes.
- R3: A 0x55 feed write that is not armed by a directly preceding 0xAA commits nothing. A feed write of any value other than 0x55 while armed, 0xAA included, disarms the sequence and commits nothing. A new 0xAA is then needed.
- R4: While the sequence is armed, any bus access (read or write) that is not a feed write disarms it, and nothing is committed.
- R5: STAT (address 2) reads the active multiplier in bits 4:0, the active divider in bits 6:5, active enable in bit 8, active connect in bit 9 and lock in bit 10. Bit 7 and bits 15:11 read 0.
- R6: `clk_sel` is 1 only when both the active enable and the active connect are 1. Connect without enable gives `clk_sel` = 0 and `pll_en` = 0.
- R7: While `pwr_down` is high, each clock edge clears the active enable and the active connect. This takes priority over a commit in the same cycle. The active multiplier and divider are kept.
- R8: The lock bit of STAT follows `lock_in` in the same cycle. `lock_irq` equals `lock_in` AND the interrupt-enable bit (IEN, address 4, bit 0), also in the same cycle.
- R9: After reset, all staged and active fields, IEN and `clk_sel` are 0, and the sequence is disarmed.
- R10: FEED reads as 0. IEN reads back its bit 0. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pwr_down | input | 1 | Power-down request, clears active enable and connect |
| lock_in | input | 1 | Lock indication from the multiplier loop |
| clk_sel | output | 1 | 1 selects the multiplied clock, 0 the oscillator |
| lock_irq | output | 1 | Lock interrupt request |
| pll_mult | output | 5 | Active multiplier value |
| pll_div | output | 2 | Active divider value |
| pll_en | output | 1 | Active enable to the loop |

## Verification
Read data, the status lock bit and `lock_irq` are combinational, so they are due in the same cycle as the address or the `lock_in` change. A commit, a staged write and a power-down act at the next rising edge, and their effect is visible from the cycle after it. The bench drives inputs just after a rising edge and compares every output against a behavioural model at the falling edge. It updates the model at the rising edge, so each result is taken in the cycle it is due and never at the edge where it changes. Directed checks after each scenario compare against values worked out by hand for aborted, cancelled, delayed and power-down sequences.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic con;
      logic en;
   } ctrl_t;

   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_CFG  = 1;
   localparam int unsigned A_STAT = 2;
   localparam int unsigned A_FEED = 3;
   localparam int unsigned A_IEN  = 4;

endpackage

// File: rtl/pllctl_feed.sv
// Two-write unlock detector: arm on KEY_ARM, fire on KEY_FIRE.
module pllctl_feed #(
   parameter int unsigned          KEY_W    = 8,
   parameter logic [KEY_W-1:0]     KEY_ARM  = 8'hAA,
   parameter logic [KEY_W-1:0]     KEY_FIRE = 8'h55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_act,
   input  logic             feed_wr,
   input  logic [KEY_W-1:0] key,
   output logic             commit
);
   import pllctl_pkg::*;

   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE:  if (feed_wr && key == KEY_ARM) state_d = SEQ_ARMED;
         SEQ_ARMED: if (bus_act) state_d = SEQ_IDLE;
         default:   state_d = SEQ_IDLE;
      endcase
   end

   assign commit = (state_q == SEQ_ARMED) && feed_wr && (key == KEY_FIRE);

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/pllctl_regs.sv
// Staged and active copies of the control and configuration fields.
module pllctl_regs #(
   parameter int unsigned MULT_W = 5,
   parameter int unsigned DIV_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctrl,
   input  logic                wr_cfg,
   input  pllctl_pkg::ctrl_t   ctrl_d,
   input  logic [MULT_W-1:0]   mult_d,
   input  logic [DIV_W-1:0]    div_d,
   input  logic                commit,
   input  logic                pwr_down,
   output pllctl_pkg::ctrl_t   stg_ctrl,
   output logic [MULT_W-1:0]   stg_mult,
   output logic [DIV_W-1:0]    stg_div,
   output pllctl_pkg::ctrl_t   act_ctrl,
   output logic [MULT_W-1:0]   act_mult,
   output logic [DIV_W-1:0]    act_div
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_ctrl <= '0;
         stg_mult <= '0;
         stg_div  <= '0;
      end else begin
         if (wr_ctrl) stg_ctrl <= ctrl_d;
         if (wr_cfg) begin
            stg_mult <= mult_d;
            stg_div  <= div_d;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_ctrl <= '0;
         act_mult <= '0;
         act_div  <= '0;
      end else begin
         if (commit) begin
            act_ctrl <= stg_ctrl;
            act_mult <= stg_mult;
            act_div  <= stg_div;
         end
         if (pwr_down) act_ctrl <= '0;
      end
   end

endmodule

// File: rtl/pllctl_irq.sv
// Lock interrupt gate; IRQ_REG selects a flopped or a direct request.
module pllctl_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   input  logic ien,
   output logic irq
);

   if (IRQ_REG) begin : g_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= lock_in & ien;
      end
   end else begin : g_direct
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = lock_in & ien;
   end

endmodule

// File: rtl/pllctl_unit.sv
module pllctl_unit #(
   parameter int unsigned      DATA_W   = 16,
   parameter int unsigned      ADDR_W   = 3,
   parameter int unsigned      MULT_W   = 5,
   parameter int unsigned      DIV_W    = 2,
   parameter int unsigned      KEY_W    = 8,
   parameter logic [KEY_W-1:0] KEY_ARM  = 8'hAA,
   parameter logic [KEY_W-1:0] KEY_FIRE = 8'h55,
   parameter bit               IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pwr_down,
   input  logic              lock_in,
   output logic              clk_sel,
   output logic              lock_irq,
   output logic [MULT_W-1:0] pll_mult,
   output logic [DIV_W-1:0]  pll_div,
   output logic              pll_en
);
   import pllctl_pkg::*;

   localparam int unsigned DIV_LSB  = MULT_W;
   localparam int unsigned CFG_W    = MULT_W + DIV_W;
   localparam int unsigned EN_BIT   = CFG_W + 1;
   localparam int unsigned CON_BIT  = EN_BIT + 1;
   localparam int unsigned LOCK_BIT = EN_BIT + 2;
   localparam int unsigned STAT_W   = LOCK_BIT + 1;

   if (DATA_W < STAT_W) begin : g_bad_data_w
      $error("pllctl_unit: DATA_W too narrow for the status word");
   end
   if (DATA_W < KEY_W) begin : g_bad_key_w
      $error("pllctl_unit: DATA_W narrower than the feed key");
   end
   if (KEY_ARM == KEY_FIRE) begin : g_bad_keys
      $error("pllctl_unit: feed keys must differ");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("pllctl_unit: ADDR_W must reach five registers");
   end

   logic hit_ctrl, hit_cfg, hit_feed, hit_ien, feed_wr, commit;
   logic ien_q;
   ctrl_t stg_ctrl, act_ctrl, ctrl_d;
   logic [MULT_W-1:0] stg_mult, act_mult;
   logic [DIV_W-1:0]  stg_div, act_div;

   assign hit_ctrl = bus_addr == ADDR_W'(A_CTRL);
   assign hit_cfg  = bus_addr == ADDR_W'(A_CFG);
   assign hit_feed = bus_addr == ADDR_W'(A_FEED);
   assign hit_ien  = bus_addr == ADDR_W'(A_IEN);
   assign feed_wr  = bus_sel && bus_wr && hit_feed;
   assign ctrl_d   = ctrl_t'(bus_wdata[1:0]);

   pllctl_feed #(
      .KEY_W(KEY_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
   ) u_feed (
      .clk(clk), .rst_n(rst_n), .bus_act(bus_sel), .feed_wr(feed_wr),
      .key(bus_wdata[KEY_W-1:0]), .commit(commit)
   );

   pllctl_regs #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(bus_sel && bus_wr && hit_ctrl),
      .wr_cfg(bus_sel && bus_wr && hit_cfg),
      .ctrl_d(ctrl_d),
      .mult_d(bus_wdata[MULT_W-1:0]),
      .div_d(bus_wdata[DIV_LSB +: DIV_W]),
      .commit(commit), .pwr_down(pwr_down),
      .stg_ctrl(stg_ctrl), .stg_mult(stg_mult), .stg_div(stg_div),
      .act_ctrl(act_ctrl), .act_mult(act_mult), .act_div(act_div)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                         ien_q <= 1'b0;
      else if (bus_sel && bus_wr && hit_ien) ien_q <= bus_wdata[0];
   end

   pllctl_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .ien(ien_q), .irq(lock_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[1:0] = stg_ctrl;
      end else if (hit_cfg) begin
         bus_rdata[MULT_W-1:0]      = stg_mult;
         bus_rdata[DIV_LSB +: DIV_W] = stg_div;
      end else if (bus_addr == ADDR_W'(A_STAT)) begin
         bus_rdata[MULT_W-1:0]      = act_mult;
         bus_rdata[DIV_LSB +: DIV_W] = act_div;
         bus_rdata[EN_BIT]          = act_ctrl.en;
         bus_rdata[CON_BIT]         = act_ctrl.con;
         bus_rdata[LOCK_BIT]        = lock_in;
      end else if (hit_ien) begin
         bus_rdata[0] = ien_q;
      end
   end

   assign clk_sel  = act_ctrl.en & act_ctrl.con;
   assign pll_en   = act_ctrl.en;
   assign pll_mult = act_mult;
   assign pll_div  = act_div;

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/pllctl_chk.sv
module pllctl_chk #(
   parameter int unsigned      DATA_W   = 16,
   parameter int unsigned      ADDR_W   = 3,
   parameter int unsigned      MULT_W   = 5,
   parameter int unsigned      DIV_W    = 2,
   parameter int unsigned      KEY_W    = 8,
   parameter logic [KEY_W-1:0] KEY_FIRE = 8'h55,
   parameter bit               IRQ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              pwr_down,
   input logic              lock_in,
   input logic              clk_sel,
   input logic              lock_irq,
   input logic [MULT_W-1:0] pll_mult,
   input logic [DIV_W-1:0]  pll_div,
   input logic              pll_en
);
   import pllctl_pkg::*;

   localparam int unsigned RSV_LO  = MULT_W + DIV_W;
   localparam int unsigned RSV_HI  = RSV_LO + 4;

   logic fire;
   assign fire = bus_sel && bus_wr && bus_addr == ADDR_W'(A_FEED)
                 && bus_wdata[KEY_W-1:0] == KEY_FIRE;

   // R2
   hold_without_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(pll_mult) && $stable(pll_div));

   // R6
   sel_rise_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_sel) |-> $past(fire));

   // R7
   pdown_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !clk_sel && !pll_en);

   // R5
   stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(A_STAT) |->
         bus_rdata[RSV_LO] == 1'b0 && (bus_rdata >> RSV_HI) == '0);

   // R10
   feed_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(A_FEED) |-> bus_rdata == '0);

   if (!IRQ_REG) begin : g_irq_chk
      // R8
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lock_irq |-> lock_in);
   end

endmodule

bind pllctl_unit pllctl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MULT_W(MULT_W), .DIV_W(DIV_W),
   .KEY_W(KEY_W), .KEY_FIRE(KEY_FIRE), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pwr_down(pwr_down), .lock_in(lock_in), .clk_sel(clk_sel),
   .lock_irq(lock_irq), .pll_mult(pll_mult), .pll_div(pll_div), .pll_en(pll_en)
);

// File: tb/pllctl_unit_bench.sv
`timescale 1ns/1ps
module pllctl_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        pwr_down = 1'b0, lock_in = 1'b0;
   logic        clk_sel, lock_irq, pll_en;
   logic [4:0]  pll_mult;
   logic [1:0]  pll_div;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pllctl_unit u_pllctl_unit (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwr_down(pwr_down), .lock_in(lock_in), .clk_sel(clk_sel),
      .lock_irq(lock_irq), .pll_mult(pll_mult), .pll_div(pll_div), .pll_en(pll_en)
   );

   // behavioural reference model
   bit      m_armed;
   bit      s_en, s_con, a_en, a_con, m_ien;
   int      s_mult, s_div, a_mult, a_div;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_armed = 0; s_en = 0; s_con = 0; a_en = 0; a_con = 0; m_ien = 0;
         s_mult = 0; s_div = 0; a_mult = 0; a_div = 0;
      end else begin
         bit fw, go;
         fw = bus_sel && bus_wr && bus_addr == 3'd3;
         go = m_armed && fw && bus_wdata[7:0] == 8'h55;
         if (!m_armed) m_armed = fw && bus_wdata[7:0] == 8'hAA;
         else if (bus_sel) m_armed = 0;
         if (go) begin
            a_en = s_en; a_con = s_con; a_mult = s_mult; a_div = s_div;
         end
         if (pwr_down) begin a_en = 0; a_con = 0; end
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               3'd0: begin s_en = bus_wdata[0]; s_con = bus_wdata[1]; end
               3'd1: begin s_mult = int'(bus_wdata[4:0]); s_div = int'(bus_wdata[6:5]); end
               3'd4: m_ien = bus_wdata[0];
               default: ;
            endcase
         end
      end
   end

   function automatic int exp_rdata(input logic [2:0] a);
      case (a)
         3'd0: return int'(s_en) + 2 * int'(s_con);
         3'd1: return s_mult + 32 * s_div;
         3'd2: return a_mult + 32 * a_div + 256 * int'(a_en) + 512 * int'(a_con)
                      + 1024 * int'(lock_in);
         3'd4: return int'(m_ien);
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 clk_sel model", int'(clk_sel), int'(a_en & a_con));
         check("R8 lock_irq model", int'(lock_irq), int'(lock_in & m_ien));
         check("R2 pll_mult model", int'(pll_mult), a_mult);
         check("R2 pll_div model", int'(pll_div), a_div);
         check("R7 pll_en model", int'(pll_en), int'(a_en));
         check("R1/R5/R10 rdata model", int'(bus_rdata), exp_rdata(bus_addr));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic feed(input logic [7:0] k);
      wr(3'd3, {8'h00, k});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic rd_chk(input logic [2:0] a, input string tag, input int exp);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk);
      check(tag, int'(bus_rdata), exp);
      @(posedge clk); #1;
      bus_sel = 0;
   endtask

   task automatic mid_chk(input string tag, input int act_sel, input int exp);
      check(tag, act_sel, exp);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      check("R9 clk_sel in reset", int'(clk_sel), 0);
      @(posedge clk); #1;
      rst_n = 1;
      @(negedge clk);
      check("R9 clk_sel after reset", int'(clk_sel), 0);
      check("R9 pll_mult after reset", int'(pll_mult), 0);
      check("R9 ctrl readback", int'(bus_rdata), 0);
      @(posedge clk); #1;
      rd_chk(3'd4, "R9 ien after reset", 0);

      // R1 staging
      wr(3'd1, 16'h0047);
      wr(3'd0, 16'h0003);
      rd_chk(3'd1, "R1 cfg staged readback", 16'h0047);
      check("R1 active mult untouched", int'(pll_mult), 0);
      check("R1 clk_sel untouched", int'(clk_sel), 0);

      // R2 commit
      feed(8'hAA); feed(8'h55);
      @(negedge clk);
      check("R2 mult committed", int'(pll_mult), 7);
      check("R2 div committed", int'(pll_div), 2);
      check("R6 connected", int'(clk_sel), 1);
      @(posedge clk); #1;
      rd_chk(3'd2, "R5 status word", 16'h0347);

      wr(3'd1, 16'hFFFF);
      @(negedge clk);
      check("R1 staged write leaves active", int'(pll_mult), 7);
      @(posedge clk); #1;

      // R3 bad sequences
      feed(8'h55); idle(1);
      @(negedge clk); check("R3 lone fire key", int'(pll_mult), 7);
      @(posedge clk); #1;
      feed(8'hAA); feed(8'hAA); feed(8'h55); idle(1);
      @(negedge clk); check("R3 double arm key", int'(pll_mult), 7);
      @(posedge clk); #1;
      feed(8'hAA); feed(8'h12); feed(8'h55); idle(1);
      @(negedge clk); check("R3 wrong second key", int'(pll_mult), 7);
      @(posedge clk); #1;

      // R4 foreign access cancels
      feed(8'hAA); rd_chk(3'd0, "R4 ctrl read mid-sequence", 3); feed(8'h55); idle(1);
      @(negedge clk); check("R4 cancelled by access", int'(pll_mult), 7);
      @(posedge clk); #1;

      // R2 idle gap allowed
      feed(8'hAA); idle(3); feed(8'h55);
      @(negedge clk);
      check("R2 gap commit mult", int'(pll_mult), 31);
      check("R2 gap commit div", int'(pll_div), 3);
      @(posedge clk); #1;
      bus_sel = 1; bus_addr = 3'd2;
      @(negedge clk);
      check("R5 reserved bit 7", int'(bus_rdata[7]), 0);
      check("R5 reserved bits 15:11", int'(bus_rdata[15:11]), 0);
      @(posedge clk); #1; bus_sel = 0;

      // R6 connect without enable
      wr(3'd0, 16'h0002); feed(8'hAA); feed(8'h55);
      @(negedge clk);
      check("R6 connect only bypass", int'(clk_sel), 0);
      check("R6 connect only enable", int'(pll_en), 0);
      @(posedge clk); #1;
      rd_chk(3'd2, "R6 status connect bit", 16'h027F);

      // R7 power-down
      wr(3'd0, 16'h0003); feed(8'hAA); feed(8'h55);
      @(negedge clk); check("R7 connected before", int'(clk_sel), 1);
      @(posedge clk); #1;
      pwr_down = 1; idle(1); pwr_down = 0;
      @(negedge clk);
      check("R7 power-down bypass", int'(clk_sel), 0);
      check("R7 power-down keeps mult", int'(pll_mult), 31);
      @(posedge clk); #1;
      feed(8'hAA); pwr_down = 1; feed(8'h55); pwr_down = 0;
      @(negedge clk);
      check("R7 power-down beats commit", int'(pll_en), 0);
      @(posedge clk); #1;

      // R8 lock and interrupt
      lock_in = 1; idle(1);
      @(negedge clk); check("R8 irq masked", int'(lock_irq), 0);
      @(posedge clk); #1;
      rd_chk(3'd2, "R8 status lock bit", 16'h047F);
      wr(3'd4, 16'h0001);
      @(negedge clk); check("R8 irq raised", int'(lock_irq), 1);
      @(posedge clk); #1;
      rd_chk(3'd4, "R10 ien readback", 1);
      rd_chk(3'd3, "R10 feed reads zero", 0);
      rd_chk(3'd6, "R10 unmapped reads zero", 0);
      lock_in = 0; idle(1);
      @(negedge clk); check("R8 irq follows lock", int'(lock_irq), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule